// File: doc/BRIEF.md
# PCM Timeslot Serial Port

This block carries one voice sample per frame in each direction over a serial PCM highway. It runs directly on the highway bit clock. A rising edge on the frame sync restarts a bit-clock position counter. Transmission of the outgoing sample begins when that position equals a programmable transmit start value. Reception of the incoming sample begins when it equals a separate receive start value. Both start values count bit clocks from the frame sync, so the same block serves short-sync, long-sync and offset-channel layouts.

The transmit pin is modelled as a data output and an output enable. The enable is high only during the port's own slot, so several ports can share one highway wire. Three mode inputs set the behaviour. The first picks an 8-bit or 16-bit sample. The second picks one bit clock per data bit, or two bit clocks per data bit. The third picks whether the driver lets go on the falling clock edge inside the last bit or on the rising edge after it.

Top module: `pcm_slot_port`

## Requirements
- R1: The bit-clock period that begins with the rising `pclk` edge on which `fsync` is first seen high (after being seen low) is position 0. Each later period is one position higher, up to a saturating maximum of 2^CNT_W-1. A second rising edge of `fsync` restarts the count at 0.
- R2: At the rising edge that begins position `tx_start`, `dtx_out` presents the sample MSB first. It moves to the next bit on the rising edge after each bit time.
- R3: `dtx_oe` is high from the rising edge that begins position `tx_start` through the last clock of the slot. It is low at all other times, including before the first frame sync.
- R4: With `early_release`=1, `dtx_oe` falls on the falling `pclk` edge in the last clock of the slot. With `early_release`=0, it falls on the rising edge that follows that clock.
- R5: With `wide_mode`=0, a sample is 8 bits and uses `tx_sample[7:0]`. With `wide_mode`=1, a sample is 16 bits and uses all of `tx_sample`.
- R6: With `gci_mode`=1, each data bit lasts two `pclk` periods on both transmit and receive, so a slot spans twice as many clocks.
- R7: `drx` is sampled MSB first on falling `pclk` edges, starting at position `rx_start`. In double-clock mode the sample is taken on the falling edge of the second clock of each bit. In the period after the slot's last clock, `rx_valid` is high for exactly one cycle. `rx_data` then holds the sample until the next one completes; an 8-bit sample is zero-extended into `rx_data[15:8]`.
- R8: A start value that the position never reaches within a frame causes no transfer in that direction: `dtx_oe` stays low, or `rx_valid` never rises.
- R9: The transmit sample is captured from `tx_sample` at the frame sync edge. Later changes to `tx_sample` do not alter the sample sent in that frame.
- R10: `rst` is synchronous and active high. While it is held, `dtx_oe`=0, `rx_valid`=0 and `rx_data`=0.
- R11: A frame sync held high for several clocks restarts the count only once, at its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Highway bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync; its rising edge starts a frame |
| wide_mode | input | 1 | 1 = 16-bit samples, 0 = 8-bit samples |
| gci_mode | input | 1 | 1 = two clocks per data bit |
| early_release | input | 1 | 1 = release driver on falling edge in the last bit |
| tx_start | input | CNT_W | Transmit start position in clocks after frame sync |
| rx_start | input | CNT_W | Receive start position in clocks after frame sync |
| tx_sample | input | SW | Sample to transmit, captured at frame start |
| dtx_out | output | 1 | Transmit serial data |
| dtx_oe | output | 1 | Transmit driver enable |
| drx | input | 1 | Receive serial data |
| rx_data | output | SW | Last received sample |
| rx_valid | output | 1 | One-cycle pulse when a new sample is in `rx_data` |

## Verification
There is one register stage between the frame sync and the position counter. Position 0 is therefore the period after the edge on which the sync is first seen. The first transmit bit and `dtx_oe` appear on the rising edge that opens position `tx_start`. With early release, `dtx_oe` drops half a period early. `rx_valid` and the new `rx_data` appear on the rising edge one clock after the slot's last clock.

The bench steps a behavioural model at each rising edge. It then compares data, enable and receive outputs a quarter period after that edge. It compares the enable again a quarter period after the falling edge, which is how the two release edges are told apart.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
package pcm_slot_pkg;

    typedef struct packed {
        logic wide;
        logic gci;
        logic early;
    } pcm_mode_t;

    typedef enum logic {
        LANE_IDLE = 1'b0,
        LANE_BUSY = 1'b1
    } lane_state_t;

    function automatic int sample_bits(input pcm_mode_t m, input int sw);
        return m.wide ? sw : sw / 2;
    endfunction

    function automatic int slot_clocks(input pcm_mode_t m, input int sw);
        return m.gci ? 2 * sample_bits(m, sw) : sample_bits(m, sw);
    endfunction

    // true on the clock that closes a data bit
    function automatic logic bit_closes(input pcm_mode_t m, input logic k_lsb);
        return m.gci ? k_lsb : 1'b1;
    endfunction

endpackage

// File: rtl/pcm_frame_counter.sv
`timescale 1ns/1ps
module pcm_frame_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fsync,
    output logic             frame_start,
    output logic             step,
    output logic [CNT_W-1:0] pos_next,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

    logic             fs_q;
    logic             run_q;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        frame_start = fsync & ~fs_q;
        step        = frame_start | (run_q & (cnt_q != POS_MAX));
        pos_next    = frame_start ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q  <= 1'b0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            fs_q <= fsync;
            if (frame_start) run_q <= 1'b1;
            if (step) cnt_q <= pos_next;
        end
    end

    assign pos = cnt_q;
endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane
    import pcm_slot_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pcm_mode_t     mode,
    input  logic          hit,
    input  logic          frame_start,
    input  logic [SW-1:0] sample,
    output logic          dtx,
    output logic          oe,
    output logic          busy
);
    localparam int HW = SW / 2;
    localparam int KW = $clog2(2 * SW + 1);

    lane_state_t   st_q;
    logic [SW-1:0] hold_q;
    logic [SW-1:0] sh_q;
    logic [SW-1:0] src;
    logic [SW-1:0] aligned;
    logic [KW-1:0] k_q;
    logic [KW-1:0] k_last;
    logic          last;
    logic          rel_q;

    always_comb begin
        src     = frame_start ? sample : hold_q;
        aligned = mode.wide ? src : {src[HW-1:0], {HW{1'b0}}};
        k_last  = KW'(slot_clocks(mode, SW) - 1);
        last    = (st_q == LANE_BUSY) && (k_q == k_last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LANE_IDLE;
            hold_q <= '0;
            sh_q   <= '0;
            k_q    <= '0;
        end else begin
            if (frame_start) hold_q <= sample;
            if (hit) begin
                st_q <= LANE_BUSY;
                k_q  <= '0;
                sh_q <= aligned;
            end else if (st_q == LANE_BUSY) begin
                if (last) begin
                    st_q <= LANE_IDLE;
                end else begin
                    k_q <= k_q + 1'b1;
                    if (bit_closes(mode, k_q[0])) sh_q <= {sh_q[SW-2:0], 1'b0};
                end
            end
        end
    end

    // half-cycle release flag, set on the falling edge of the last clock
    always_ff @(negedge clk) begin
        if (rst) rel_q <= 1'b0;
        else     rel_q <= last & mode.early;
    end

    assign busy = (st_q == LANE_BUSY);
    assign oe   = busy & ~(rel_q & last);
    assign dtx  = oe & sh_q[SW-1];
endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane
    import pcm_slot_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  pcm_mode_t     mode,
    input  logic          hit,
    input  logic          drx,
    output logic [SW-1:0] data,
    output logic          valid,
    output logic          busy
);
    localparam int HW = SW / 2;
    localparam int KW = $clog2(2 * SW + 1);

    lane_state_t   st_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] k_last;
    logic          last;
    logic [SW-1:0] sh_q;
    logic [SW-1:0] word;
    logic [SW-1:0] data_q;
    logic          valid_q;

    always_comb begin
        k_last = KW'(slot_clocks(mode, SW) - 1);
        last   = (st_q == LANE_BUSY) && (k_q == k_last);
        word   = mode.wide ? sh_q : {{HW{1'b0}}, sh_q[HW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= LANE_IDLE;
            k_q     <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (hit) begin
                st_q <= LANE_BUSY;
                k_q  <= '0;
            end else if (st_q == LANE_BUSY) begin
                if (last) begin
                    st_q    <= LANE_IDLE;
                    data_q  <= word;
                    valid_q <= 1'b1;
                end else begin
                    k_q <= k_q + 1'b1;
                end
            end
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if ((st_q == LANE_BUSY) && bit_closes(mode, k_q[0])) begin
            sh_q <= {sh_q[SW-2:0], drx};
        end
    end

    assign data  = data_q;
    assign valid = valid_q;
    assign busy  = (st_q == LANE_BUSY);
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int SW    = 16
) (
    input  logic             pclk,
    input  logic             rst,
    input  logic             fsync,
    input  logic             wide_mode,
    input  logic             gci_mode,
    input  logic             early_release,
    input  logic [CNT_W-1:0] tx_start,
    input  logic [CNT_W-1:0] rx_start,
    input  logic [SW-1:0]    tx_sample,
    output logic             dtx_out,
    output logic             dtx_oe,
    input  logic             drx,
    output logic [SW-1:0]    rx_data,
    output logic             rx_valid
);
    pcm_mode_t        mode;
    logic             frame_start;
    logic             step;
    logic [CNT_W-1:0] pos_next;
    logic [CNT_W-1:0] pos;
    logic             tx_hit;
    logic             rx_hit;
    logic             tx_busy;
    logic             rx_busy;

    assign mode   = '{wide: wide_mode, gci: gci_mode, early: early_release};
    assign tx_hit = step && (pos_next == tx_start);
    assign rx_hit = step && (pos_next == rx_start);

    pcm_frame_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (pclk),
        .rst         (rst),
        .fsync       (fsync),
        .frame_start (frame_start),
        .step        (step),
        .pos_next    (pos_next),
        .pos         (pos)
    );

    pcm_tx_lane #(.SW(SW)) u_tx (
        .clk         (pclk),
        .rst         (rst),
        .mode        (mode),
        .hit         (tx_hit),
        .frame_start (frame_start),
        .sample      (tx_sample),
        .dtx         (dtx_out),
        .oe          (dtx_oe),
        .busy        (tx_busy)
    );

    pcm_rx_lane #(.SW(SW)) u_rx (
        .clk   (pclk),
        .rst   (rst),
        .mode  (mode),
        .hit   (rx_hit),
        .drx   (drx),
        .data  (rx_data),
        .valid (rx_valid),
        .busy  (rx_busy)
    );
endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk #(
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             fsync,
    input logic             dtx_oe,
    input logic             rx_valid,
    input logic             tx_busy,
    input logic             rx_busy,
    input logic [CNT_W-1:0] pos,
    input logic [CNT_W-1:0] tx_start,
    input logic [CNT_W-1:0] rx_start
);
    p_sync_restart_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |=> (pos == '0));

    p_tx_starts_on_match_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> (pos == tx_start));

    p_oe_only_in_slot_r3: assert property (@(posedge clk) disable iff (rst)
        dtx_oe |-> tx_busy);

    p_rx_starts_on_match_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_busy) |-> (pos == rx_start));

    p_valid_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.CNT_W(CNT_W)) i_chk (
    .clk      (pclk),
    .rst      (rst),
    .fsync    (fsync),
    .dtx_oe   (dtx_oe),
    .rx_valid (rx_valid),
    .tx_busy  (tx_busy),
    .rx_busy  (rx_busy),
    .pos      (pos),
    .tx_start (tx_start),
    .rx_start (rx_start)
);

// File: tb/test_pcm_slot_port.sv
`timescale 1ns/1ps
module test_pcm_slot_port;
    localparam int CNT_W = 11;
    localparam int SW    = 16;
    localparam int MAXP  = (1 << CNT_W) - 1;

    logic             pclk = 1'b0;
    logic             rst = 1'b1;
    logic             fsync = 1'b0;
    logic             wide_mode = 1'b0;
    logic             gci_mode = 1'b0;
    logic             early_release = 1'b0;
    logic [CNT_W-1:0] tx_start = '0;
    logic [CNT_W-1:0] rx_start = '0;
    logic [SW-1:0]    tx_sample = '0;
    logic             drx = 1'b0;
    logic             dtx_out;
    logic             dtx_oe;
    logic [SW-1:0]    rx_data;
    logic             rx_valid;

    pcm_slot_port #(.CNT_W(CNT_W), .SW(SW)) i_pcm_slot_port (
        .pclk(pclk), .rst(rst), .fsync(fsync), .wide_mode(wide_mode),
        .gci_mode(gci_mode), .early_release(early_release),
        .tx_start(tx_start), .rx_start(rx_start), .tx_sample(tx_sample),
        .dtx_out(dtx_out), .dtx_oe(dtx_oe), .drx(drx),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    always #10 pclk = ~pclk;

    int       n_run = 0;
    int       n_fail = 0;
    bit       done = 0;
    string    scn = "reset";

    // behavioural reference state
    int          m_pos = 0;
    bit          m_run = 0;
    logic        m_fs_prev = 1'b0;
    int          tx_k = -1;
    int          rx_k = -1;
    int          m_nb = 8;
    int          m_div = 1;
    int          m_len = 8;
    logic [15:0] m_hold = '0;
    logic [15:0] m_word = '0;
    logic [15:0] rx_pat = '0;
    logic        exp_valid = 1'b0;
    logic [15:0] exp_data = '0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual %0h expected %0h at %0t", tag, scn, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit fs_edge;
        bit stepped;
        fs_edge   = fsync && !m_fs_prev;
        m_fs_prev = fsync;
        stepped   = fs_edge || (m_run && m_pos < MAXP);
        if (fs_edge) begin
            m_pos  = 0;
            m_run  = 1;
            m_hold = tx_sample;
        end else if (stepped) begin
            m_pos++;
        end
        m_nb  = wide_mode ? 16 : 8;
        m_div = gci_mode ? 2 : 1;
        m_len = m_nb * m_div;
        if (tx_k >= 0) begin
            tx_k++;
            if (tx_k == m_len) tx_k = -1;
        end
        if (stepped && m_pos == int'(tx_start)) begin
            tx_k   = 0;
            m_word = m_hold;
        end
        exp_valid = 1'b0;
        if (rx_k >= 0) begin
            rx_k++;
            if (rx_k == m_len) begin
                rx_k      = -1;
                exp_valid = 1'b1;
                exp_data  = wide_mode ? rx_pat : {8'h00, rx_pat[7:0]};
            end
        end
        if (stepped && m_pos == int'(rx_start)) rx_k = 0;
    endtask

    task automatic tick(input logic fs);
        @(posedge pclk);
        model_step();
        #5;
        fsync = fs;
        if (rx_k >= 0) drx = rx_pat[m_nb - 1 - rx_k / m_div];
        else           drx = 1'($urandom_range(0, 1));
        #2;
        // after the rising edge: R3 enable, R2 data, R7 receive
        chk(dtx_oe === (tx_k >= 0), "R3 dtx_oe", dtx_oe, tx_k >= 0);
        if (tx_k >= 0)
            chk(dtx_out === m_word[m_nb - 1 - tx_k / m_div], "R2 dtx_out bit",
                dtx_out, m_word[m_nb - 1 - tx_k / m_div]);
        chk(rx_valid === exp_valid, "R7 rx_valid", rx_valid, exp_valid);
        chk(rx_data === exp_data, "R7 rx_data", rx_data, exp_data);
        #10;
        // after the falling edge: R4 release edge
        chk(dtx_oe === ((tx_k >= 0) && !(early_release && tx_k == m_len - 1)),
            "R4 dtx_oe late half", dtx_oe,
            (tx_k >= 0) && !(early_release && tx_k == m_len - 1));
    endtask

    task automatic run_frame(input int len, input int fs_hi, input logic [15:0] smp,
                             input logic [15:0] pat, input int change_at);
        tx_sample = smp;
        rx_pat    = pat;
        for (int i = 0; i < len; i++) begin
            tick(i < fs_hi);
            if (i == change_at) tx_sample = ~smp;  // R9: must not reach the line
        end
    endtask

    task automatic set_mode(input string name, input logic w, input logic g, input logic e,
                            input int ts, input int rs);
        scn           = name;
        wide_mode     = w;
        gci_mode      = g;
        early_release = e;
        tx_start      = CNT_W'(ts);
        rx_start      = CNT_W'(rs);
    endtask

    initial begin
        #(64'd4_000_000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired in [%s]", scn);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tx_sample = 16'hFFFF;
        repeat (3) @(posedge pclk);
        #5;
        // R10: outputs cleared while reset is held
        chk(dtx_oe === 1'b0, "R10 dtx_oe in reset", dtx_oe, 0);
        chk(rx_valid === 1'b0, "R10 rx_valid in reset", rx_valid, 0);
        chk(rx_data === '0, "R10 rx_data in reset", rx_data, 0);
        rst = 1'b0;
        // idle ticks before any frame sync: R3 enable stays low
        scn = "R3 idle";
        repeat (4) tick(1'b0);

        set_mode("R1 R2 R7 basic 8-bit", 0, 0, 0, 1, 1);
        run_frame(24, 1, 16'h00A5, 16'h003C, -1);
        run_frame(24, 1, 16'h0096, 16'h00E1, -1);

        set_mode("R4 early release", 0, 0, 1, 3, 10);
        run_frame(24, 1, 16'h0081, 16'h007E, -1);
        run_frame(24, 1, 16'h00FF, 16'h0055, -1);

        set_mode("R5 wide 16-bit", 1, 0, 0, 5, 20);
        run_frame(48, 1, 16'hBEEF, 16'h1234, -1);
        run_frame(48, 1, 16'h8001, 16'hC3A5, -1);

        set_mode("R6 double clock 8-bit", 0, 1, 0, 3, 0);
        run_frame(40, 1, 16'h00C9, 16'h0093, -1);
        run_frame(40, 1, 16'h0036, 16'h00A6, -1);

        set_mode("R6 R5 double clock 16-bit early", 1, 1, 1, 0, 34);
        run_frame(72, 1, 16'hA55A, 16'h0FF0, -1);
        run_frame(72, 1, 16'h7E81, 16'hF00D, -1);

        set_mode("R11 long frame sync", 0, 0, 0, 2, 6);
        run_frame(24, 4, 16'h00D2, 16'h004B, -1);
        run_frame(24, 5, 16'h0019, 16'h00F6, -1);

        set_mode("R8 start beyond frame", 0, 0, 0, 1500, 40);
        run_frame(32, 1, 16'h00AA, 16'h00BB, -1);
        run_frame(32, 1, 16'h0055, 16'h0044, -1);

        set_mode("R9 sample held from frame start", 0, 0, 0, 8, 2);
        run_frame(24, 1, 16'h00B4, 16'h0071, 1);
        set_mode("R9 R5 sample held 16-bit", 1, 0, 0, 6, 3);
        run_frame(32, 1, 16'h6C93, 16'h2E17, 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule